// File: doc/BRIEF.md
# UART Test-Mode FIFO Access Controller

This block sits beside a UART's serial engine and owns the transmit and receive byte FIFOs. It also owns a small set of test controls. A simple single-cycle bus slave decodes two words. The first is a test control word that holds three mode bits. The second is a test data word. While direct FIFO access is switched on, bus writes to the test data word are pushed into the receive FIFO and bus reads of it pop the transmit FIFO. Software can therefore fill the receive path and drain the transmit path without any serial traffic.

In normal operation the host side fills the transmit FIFO and empties the receive FIFO. The serial engine does the opposite. While direct access is on, the engine-side ports of both FIFOs are locked out so that the bus alone drives them. A third control bit selects how the infrared receiver behaves while the infrared transmitter is busy. When the bit is clear, the receiver is disabled (half duplex). When the bit is set, the receiver stays on (full duplex), which is needed for loopback through the infrared path.

Top module: `uart_fifo_test_ctrl`

## Requirements
- R1: After a synchronous reset, the control word reads 0, both FIFOs are empty with level 0, `test_overrun` is 0, `test_mode` is 0, and `rx_enable` is 1 while `sir_tx_active` and `loopback_en` are low.
- R2: The control word sits at offset 0x080. Bits 2:0 hold, from bit 0 upward, the test enable, the direct FIFO access enable and the infrared full-duplex enable. Bits 31:3 always read zero. `test_mode` follows bit 0.
- R3: While bit 1 is set, a bus write to offset 0x08C pushes `bus_wdata[7:0]` into the receive FIFO. The host then reads the bytes back from `host_rx_data` in arrival order.
- R4: While bit 1 is set, a bus read of offset 0x08C returns the transmit FIFO's oldest byte in bits 7:0, with bits 31:8 at zero, and removes that byte.
- R5: While bit 1 is clear, writes to 0x08C leave the receive FIFO unchanged, and reads of 0x08C return zero and leave the transmit FIFO unchanged.
- R6: A direct read of 0x08C while the transmit FIFO is empty returns zero and leaves the level at 0.
- R7: A direct write while the receive FIFO is full is discarded and sets `test_overrun`. That flag stays set until reset.
- R8: `rx_enable` is 0 whenever `sir_tx_active` is high and bit 2 is clear. When bit 2 is set, `rx_enable` is 1 regardless of `sir_tx_active`.
- R9: While `loopback_en` is high, `rx_enable` is 1 only if bit 2 is set.
- R10: Each FIFO holds 16 bytes in first-in first-out order. It reports its level (0 to 16) along with full and empty flags. A push into a full FIFO from the host side is dropped.
- R11: While bit 1 is set, `eng_rx_push` and `eng_tx_pop` have no effect. While bit 1 is clear, they push into the receive FIFO and pop from the transmit FIFO.
- R12: Reads of any other offset, including 0x084, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 8 | Write data lane |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| host_tx_wr | input | 1 | Host push into the transmit FIFO |
| host_tx_data | input | 8 | Byte for host push |
| host_rx_rd | input | 1 | Host pop from the receive FIFO |
| host_rx_data | output | 8 | Oldest receive byte |
| eng_tx_pop | input | 1 | Engine pop from the transmit FIFO |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine push into the receive FIFO |
| eng_rx_data | input | 8 | Byte for engine push |
| sir_tx_active | input | 1 | Infrared transmitter busy |
| loopback_en | input | 1 | Loopback enable from the main control word |
| rx_enable | output | 1 | Infrared receive path enable |
| test_mode | output | 1 | Test enable bit |
| test_overrun | output | 1 | Sticky direct-write overrun |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 5 | Transmit FIFO fill level |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 5 | Receive FIFO fill level |

## Verification
The assertions assume that a bus access lasts exactly one cycle. They also assume that nothing outside the block drives the FIFOs, so fill levels move only through the listed push and pop strobes. The loopback and infrared-busy inputs are treated as free-running levels. The stimulus holds each bus strobe for a single cycle and drives every input away from the clock edge. Its random phase mixes host pushes, host pops and direct accesses, which run the receive FIFO into overrun and the transmit FIFO dry. Directed cases toggle the engine strobes on both sides of the access-enable bit.

// File: rtl/uft_pkg.sv
`timescale 1ns/1ps
package uft_pkg;
    localparam int unsigned UFT_ADDR_W = 12;
    localparam int unsigned UFT_BUS_W  = 32;
    localparam int unsigned UFT_CTRL_W = 3;

    localparam logic [UFT_ADDR_W-1:0] UFT_OFS_CTRL  = 12'h080;
    localparam logic [UFT_ADDR_W-1:0] UFT_OFS_ITIN  = 12'h084;
    localparam logic [UFT_ADDR_W-1:0] UFT_OFS_TDATA = 12'h08C;

    // bit 0 = test enable, bit 1 = direct FIFO access, bit 2 = IR full duplex
    typedef struct packed {
        logic sir_fd;
        logic fifo_access;
        logic test_mode;
    } uft_ctrl_t;

    typedef enum logic [1:0] {
        UFT_SEL_NONE,
        UFT_SEL_CTRL,
        UFT_SEL_TDATA,
        UFT_SEL_ZERO
    } uft_sel_e;

    function automatic uft_sel_e uft_decode(input logic sel, input logic [UFT_ADDR_W-1:0] a);
        if (!sel)                return UFT_SEL_NONE;
        if (a == UFT_OFS_CTRL)   return UFT_SEL_CTRL;
        if (a == UFT_OFS_TDATA)  return UFT_SEL_TDATA;
        return UFT_SEL_ZERO;
    endfunction

    // receiver on when full duplex is chosen, or when the IR transmitter is idle
    // and loopback is not requested
    function automatic logic uft_rx_gate(input logic sir_fd, input logic tx_act, input logic lbe);
        return sir_fd | (~tx_act & ~lbe);
    endfunction
endpackage

// File: rtl/uft_fifo.sv
`timescale 1ns/1ps
module uft_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign level   = cnt;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/uft_regs.sv
`timescale 1ns/1ps
module uft_regs
    import uft_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [UFT_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [UFT_BUS_W-1:0]  bus_rdata,
    input  logic                  tx_empty,
    input  logic [DATA_W-1:0]     tx_head,
    input  logic                  rx_full,
    output uft_ctrl_t             ctrl,
    output logic                  test_push,
    output logic                  test_pop,
    output logic                  overrun
);
    uft_sel_e sel;
    logic     tdata_wr, tdata_rd;

    assign sel       = uft_decode(bus_sel, bus_addr);
    assign tdata_wr  = (sel == UFT_SEL_TDATA) & bus_wr & ctrl.fifo_access;
    assign tdata_rd  = (sel == UFT_SEL_TDATA) & ~bus_wr & ctrl.fifo_access;
    assign test_push = tdata_wr & ~rx_full;
    assign test_pop  = tdata_rd & ~tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            overrun <= 1'b0;
        end else begin
            if (sel == UFT_SEL_CTRL && bus_wr) ctrl <= uft_ctrl_t'(bus_wdata[UFT_CTRL_W-1:0]);
            if (tdata_wr && rx_full) overrun <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            case (sel)
                UFT_SEL_CTRL:  bus_rdata[UFT_CTRL_W-1:0] = ctrl;
                UFT_SEL_TDATA: if (test_pop) bus_rdata[DATA_W-1:0] = tx_head;
                default:       bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uft_steer.sv
`timescale 1ns/1ps
module uft_steer #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              fifo_access,
    input  logic              test_push,
    input  logic [DATA_W-1:0] test_byte,
    input  logic              test_pop,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_wdata,
    output logic              tx_pop
);
    always_comb begin
        if (fifo_access) begin
            rx_push  = test_push;
            rx_wdata = test_byte;
            tx_pop   = test_pop;
        end else begin
            rx_push  = eng_rx_push;
            rx_wdata = eng_rx_data;
            tx_pop   = eng_tx_pop;
        end
    end
endmodule

// File: rtl/uart_fifo_test_ctrl.sv
`timescale 1ns/1ps
module uart_fifo_test_ctrl
    import uft_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [UFT_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [UFT_BUS_W-1:0]  bus_rdata,
    input  logic                  host_tx_wr,
    input  logic [DATA_W-1:0]     host_tx_data,
    input  logic                  host_rx_rd,
    output logic [DATA_W-1:0]     host_rx_data,
    input  logic                  eng_tx_pop,
    output logic [DATA_W-1:0]     eng_tx_data,
    input  logic                  eng_rx_push,
    input  logic [DATA_W-1:0]     eng_rx_data,
    input  logic                  sir_tx_active,
    input  logic                  loopback_en,
    output logic                  rx_enable,
    output logic                  test_mode,
    output logic                  test_overrun,
    output logic                  tx_full,
    output logic                  tx_empty,
    output logic [LVL_W-1:0]      tx_level,
    output logic                  rx_full,
    output logic                  rx_empty,
    output logic [LVL_W-1:0]      rx_level
);
    uft_ctrl_t         ctrl_q;
    logic              test_push, test_pop;
    logic              rx_push, tx_pop;
    logic [DATA_W-1:0] rx_wdata, tx_head;
    logic              fifo_access_en, sir_fd_en;

    assign fifo_access_en = ctrl_q.fifo_access;
    assign sir_fd_en      = ctrl_q.sir_fd;
    assign test_mode      = ctrl_q.test_mode;
    assign rx_enable      = uft_rx_gate(sir_fd_en, sir_tx_active, loopback_en);
    assign eng_tx_data    = tx_head;

    uft_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_empty  (tx_empty),
        .tx_head   (tx_head),
        .rx_full   (rx_full),
        .ctrl      (ctrl_q),
        .test_push (test_push),
        .test_pop  (test_pop),
        .overrun   (test_overrun)
    );

    uft_steer #(.DATA_W(DATA_W)) u_steer (
        .fifo_access (fifo_access_en),
        .test_push   (test_push),
        .test_byte   (bus_wdata),
        .test_pop    (test_pop),
        .eng_rx_push (eng_rx_push),
        .eng_rx_data (eng_rx_data),
        .eng_tx_pop  (eng_tx_pop),
        .rx_push     (rx_push),
        .rx_wdata    (rx_wdata),
        .tx_pop      (tx_pop)
    );

    uft_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (host_tx_wr),
        .wdata (host_tx_data),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty),
        .level (tx_level)
    );

    uft_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (host_rx_rd),
        .rdata (host_rx_data),
        .full  (rx_full),
        .empty (rx_empty),
        .level (rx_level)
    );
endmodule

// File: rtl/uft_checker.sv
`timescale 1ns/1ps
module uft_checker
    import uft_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [UFT_ADDR_W-1:0] bus_addr,
    input logic [UFT_BUS_W-1:0]  bus_rdata,
    input logic                  host_tx_wr,
    input logic                  host_rx_rd,
    input logic                  eng_rx_push,
    input logic                  fifo_access,
    input logic                  sir_fd,
    input logic                  sir_tx_active,
    input logic                  loopback_en,
    input logic                  rx_enable,
    input logic                  overrun,
    input logic                  rx_full,
    input logic                  tx_empty,
    input logic [LVL_W-1:0]      tx_level,
    input logic [LVL_W-1:0]      rx_level
);
    AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == UFT_OFS_CTRL) |-> (bus_rdata[UFT_BUS_W-1:UFT_CTRL_W] == '0)); // R2
    AST_TDATA_CLOSED_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == UFT_OFS_TDATA && !fifo_access) |-> (bus_rdata == '0)); // R5
    AST_RX_HELD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!fifo_access && !eng_rx_push && !host_rx_rd) |=> $stable(rx_level)); // R5
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !host_tx_wr) |=> tx_empty); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R7
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(rx_full)); // R7
    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (rst)
        (sir_tx_active && !sir_fd) |-> !rx_enable); // R8
    AST_LOOP_NEEDS_FD: assert property (@(posedge clk) disable iff (rst)
        (loopback_en && !sir_fd) |-> !rx_enable); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(rx_level) <= int'(DEPTH)) && (int'(tx_level) <= int'(DEPTH))); // R10
endmodule

bind uart_fifo_test_ctrl uft_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_uft_checker (
    .clk           (clk),
    .rst           (rst),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .host_tx_wr    (host_tx_wr),
    .host_rx_rd    (host_rx_rd),
    .eng_rx_push   (eng_rx_push),
    .fifo_access   (fifo_access_en),
    .sir_fd        (sir_fd_en),
    .sir_tx_active (sir_tx_active),
    .loopback_en   (loopback_en),
    .rx_enable     (rx_enable),
    .overrun       (test_overrun),
    .rx_full       (rx_full),
    .tx_empty      (tx_empty),
    .tx_level      (tx_level),
    .rx_level      (rx_level)
);

// File: tb/uart_fifo_test_ctrl_bench.sv
`timescale 1ns/1ps
module uart_fifo_test_ctrl_bench;
    import uft_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        host_tx_wr = 0, host_rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [7:0]  host_tx_data = '0, eng_rx_data = '0, host_rx_data, eng_tx_data;
    logic        sir_tx_active = 0, loopback_en = 0;
    logic        rx_enable, test_mode, test_overrun, tx_full, tx_empty, rx_full, rx_empty;
    logic [4:0]  tx_level, rx_level;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit ovr_m = 0;

    always #10 clk = ~clk;

    uart_fifo_test_ctrl u_uart_fifo_test_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_tx_wr(host_tx_wr),
        .host_tx_data(host_tx_data), .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .sir_tx_active(sir_tx_active), .loopback_en(loopback_en),
        .rx_enable(rx_enable), .test_mode(test_mode), .test_overrun(test_overrun),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_level(rx_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_tdata_read(input bit acc);
        if (!acc || txq.size() == 0) return 32'h0;
        return {24'h0, txq[0]};
    endfunction

    function automatic bit exp_gate(input bit fd, input bit txa, input bit lbe);
        return fd || (!txa && !lbe);
    endfunction

    task automatic bus_op(input logic wr, input logic [11:0] a, input logic [7:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #5 rd = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic pulse(input bit txw, input logic [7:0] txd, input bit rxr,
                         input bit epop, input bit epush, input logic [7:0] ed,
                         output logic [7:0] rx_head);
        @(negedge clk);
        host_tx_wr = txw; host_tx_data = txd; host_rx_rd = rxr;
        eng_tx_pop = epop; eng_rx_push = epush; eng_rx_data = ed;
        #5 rx_head = host_rx_data;
        @(posedge clk); #1;
        host_tx_wr = 0; host_rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic check_levels(input string req);
        chk(req, {27'h0, tx_level}, txq.size());
        chk(req, {27'h0, rx_level}, rxq.size());
        chk(req, {31'h0, test_overrun}, {31'h0, ovr_m});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  hd;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_empty", {31'h0, tx_empty}, 1);
        chk("R1 rx_empty", {31'h0, rx_empty}, 1);
        chk("R1 rx_enable", {31'h0, rx_enable}, 1);
        chk("R1 test_mode", {31'h0, test_mode}, 0);
        check_levels("R1 levels");
        bus_op(0, UFT_OFS_CTRL, 0, rd);
        chk("R1 ctrl", rd, 0);

        // R2 control word, reserved bits zero
        bus_op(1, UFT_OFS_CTRL, 8'hFF, rd);
        bus_op(0, UFT_OFS_CTRL, 0, rd);
        chk("R2 ctrl readback", rd, 32'h7);
        chk("R2 test_mode", {31'h0, test_mode}, 1);
        bus_op(1, UFT_OFS_CTRL, 8'h01, rd);

        // R5 closed data word
        for (int i = 0; i < 3; i++) begin
            pulse(1, 8'hA0 + 8'(i), 0, 0, 0, 0, hd);
            txq.push_back(8'hA0 + 8'(i));
        end
        bus_op(0, UFT_OFS_TDATA, 0, rd);
        chk("R5 closed read", rd, 0);
        bus_op(1, UFT_OFS_TDATA, 8'h55, rd);
        check_levels("R5 closed levels");

        // R11 engine works when closed
        pulse(0, 0, 0, 1, 1, 8'h77, hd);
        void'(txq.pop_front());
        rxq.push_back(8'h77);
        check_levels("R11 engine open");
        pulse(0, 0, 1, 0, 0, 0, hd);
        chk("R11 engine byte", {24'h0, hd}, 8'h77);
        void'(rxq.pop_front());

        // R4 direct read pops in order, R6 empty pop
        bus_op(1, UFT_OFS_CTRL, 8'h02, rd);
        pulse(0, 0, 0, 1, 1, 8'h99, hd);
        check_levels("R11 engine locked");
        while (txq.size() > 0) begin
            bus_op(0, UFT_OFS_TDATA, 0, rd);
            chk("R4 direct read", rd, {24'h0, txq.pop_front()});
        end
        bus_op(0, UFT_OFS_TDATA, 0, rd);
        chk("R6 empty read", rd, 0);
        check_levels("R6 level");

        // R3, R7 direct writes, overrun
        for (int i = 0; i < 17; i++) begin
            bus_op(1, UFT_OFS_TDATA, 8'h10 + 8'(i), rd);
            if (rxq.size() < 16) rxq.push_back(8'h10 + 8'(i)); else ovr_m = 1;
        end
        chk("R7 rx_full", {31'h0, rx_full}, 1);
        check_levels("R7 overrun");
        while (rxq.size() > 0) begin
            pulse(0, 0, 1, 0, 0, 0, hd);
            chk("R3 rx order", {24'h0, hd}, {24'h0, rxq.pop_front()});
        end
        check_levels("R7 sticky");

        // R10 host pushes past full
        for (int i = 0; i < 17; i++) begin
            pulse(1, 8'hC0 + 8'(i), 0, 0, 0, 0, hd);
            if (txq.size() < 16) txq.push_back(8'hC0 + 8'(i));
        end
        chk("R10 tx_full", {31'h0, tx_full}, 1);
        check_levels("R10 levels");

        // R12 other offsets
        bus_op(0, UFT_OFS_ITIN, 0, rd);
        chk("R12 itin", rd, 0);
        bus_op(0, 12'h100, 0, rd);
        chk("R12 other", rd, 0);

        // R8, R9 receive gate
        for (int fd = 0; fd < 2; fd++) begin
            bus_op(1, UFT_OFS_CTRL, fd ? 8'h06 : 8'h02, rd);
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                sir_tx_active = c[0]; loopback_en = c[1];
                #2;
                chk(c[1] ? "R9 loop gate" : "R8 duplex gate", {31'h0, rx_enable},
                    {31'h0, exp_gate(fd[0], c[0], c[1])});
            end
        end
        @(negedge clk);
        sir_tx_active = 0; loopback_en = 0;
        bus_op(1, UFT_OFS_CTRL, 8'h02, rd);

        // random mixed traffic with direct access on
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 3);
            logic [7:0] b = 8'($urandom);
            case (op)
                0: begin
                    pulse(1, b, 0, 0, 0, 0, hd);
                    if (txq.size() < 16) txq.push_back(b);
                end
                1: begin
                    bus_op(0, UFT_OFS_TDATA, 0, rd);
                    chk("R4 random read", rd, exp_tdata_read(1));
                    if (txq.size() > 0) void'(txq.pop_front());
                end
                2: begin
                    bus_op(1, UFT_OFS_TDATA, b, rd);
                    if (rxq.size() < 16) rxq.push_back(b); else ovr_m = 1;
                end
                default: begin
                    pulse(0, 0, 1, 0, 0, 0, hd);
                    if (rxq.size() > 0) chk("R3 random head", {24'h0, hd}, {24'h0, rxq.pop_front()});
                end
            endcase
            check_levels("R10 random levels");
        end

        // reset again clears everything
        @(negedge clk); rst = 1;
        @(posedge clk); #1 rst = 0;
        txq.delete(); rxq.delete(); ovr_m = 0;
        check_levels("R1 second reset");
        bus_op(0, UFT_OFS_CTRL, 0, rd);
        chk("R1 ctrl after reset", rd, 0);

        finish_run();
    end

    initial begin
        process p = process::self();
        p.srandom(32'd1234);
    end
endmodule